// File: doc/BRIEF.md
# I2C Controller Event Status and Interrupt Vector

This block collects the events an I2C master bus engine reports and turns them into software-visible state and a single interrupt request. The engine signals seven kinds of event as one-cycle pulses: lost arbitration, missing acknowledge, access complete, receive byte available, transmit slot free, receive overrun and transmit underflow. Each pulse sets a sticky flag in a 16-bit status word. The bus-busy condition is a level, not an event, and appears in the status word exactly as it is driven.

Software sees the pending events in two ways. Through the status word it reads the flags and clears chosen ones by writing ones. Through the vector word it reads a small code that names the most urgent of the five interrupt-capable events, and that read clears the event it names. Each further read of the vector then gives the next pending event, so a handler can loop until the vector reads zero. A 5-bit enable word selects which of those five flags drive the interrupt line.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset the status word reads 0 (bus-busy input low), the enable word reads 0, the vector reads 0 and irq_o is low.
- R2: A one-cycle event pulse sets its status flag from the next clock edge on: arbitration lost bit 0, no acknowledge bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, transmit underflow bit 10, receive overrun bit 11.
- R3: A write to the status word (address 0) clears every latched flag whose data bit is 1; flags whose data bit is 0 keep their value.
- R4: When an event pulse and a clear of the same flag (by status write or by vector read) fall in the same cycle, the flag stays set.
- R5: Status bit 12 always equals the bus_busy_i input in the cycle it is read; a status write never changes it.
- R6: Status bits 8, 9 and 15 (address zero, addressed as slave, single byte) and bits 5 to 7, 13 and 14 read 0, and writes to them have no effect.
- R7: The enable word (address 1) stores data bits 0 to 4 on a write, with the same bit meaning as status bits 0 to 4; its bits 5 to 15 read 0.
- R8: irq_o is high exactly when some status bit among 0 to 4 and the matching enable bit are both 1; it falls right after the clock edge at which the last such flag is cleared.
- R9: The vector word (address 2) reads 0 with no flag among status bits 0 to 4 set, otherwise the code of the lowest set bit: 1 arbitration lost, 2 no acknowledge, 3 access ready, 4 receive ready, 5 transmit ready. Enable bits and status bits 10 and 11 do not affect it.
- R10: A read of the vector word clears the status flag whose code it returned, so successive reads return each pending event once, lowest code first, then 0.
- R11: Reads return data in the same cycle as reg_rd_i; address 3 reads 0; reads of addresses 0 and 1 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_arb_lost_i | input | 1 | Pulse: arbitration lost |
| ev_nack_i | input | 1 | Pulse: no acknowledge received |
| ev_acc_rdy_i | input | 1 | Pulse: access complete, registers ready |
| ev_rx_rdy_i | input | 1 | Pulse: receive data available |
| ev_tx_rdy_i | input | 1 | Pulse: transmit data wanted |
| ev_rx_ovr_i | input | 1 | Pulse: receive overrun |
| ev_tx_udf_i | input | 1 | Pulse: transmit underflow |
| bus_busy_i | input | 1 | Level: bus currently busy |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 2 | Register select: 0 status, 1 enable, 2 vector, 3 unused |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data, valid in the cycle of reg_rd_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the collision of an event pulse with a clear of the same flag in one cycle, because it needs the bus-side pulse and the register-side write to line up on the same edge. The stimulus drives both from one task step, so they share a cycle by construction, and then reads the status word back. The vector's ordering is reached by raising several events at once and draining them with back-to-back vector reads, each read compared against the code the lowest remaining flag should give.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  // Status word bit positions (fixed: the vector code and the enable word follow them)
  localparam int unsigned BIT_ARB  = 0;
  localparam int unsigned BIT_NACK = 1;
  localparam int unsigned BIT_ACC  = 2;
  localparam int unsigned BIT_RXR  = 3;
  localparam int unsigned BIT_TXR  = 4;
  localparam int unsigned BIT_AZ   = 8;
  localparam int unsigned BIT_SLV  = 9;
  localparam int unsigned BIT_UDF  = 10;
  localparam int unsigned BIT_OVR  = 11;
  localparam int unsigned BIT_BUSY = 12;
  localparam int unsigned BIT_SBD  = 15;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import i2c_evt_pkg::*;
#(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned NUM_VEC = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REG_W-1:0]   set_i,
  input  logic [REG_W-1:0]   w1c_i,
  input  logic [NUM_VEC-1:0] vclr_i,
  input  logic               busy_i,
  output logic [REG_W-1:0]   stat_o
);
  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam logic [REG_W-1:0] LATCH_MASK =
    ((ONE << NUM_VEC) - ONE) | (ONE << BIT_UDF) | (ONE << BIT_OVR);

  logic unused_bits;
  assign unused_bits = ^{set_i & ~LATCH_MASK, w1c_i & ~LATCH_MASK};

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (i == BIT_BUSY) begin : g_live
      assign stat_o[i] = busy_i;
    end else if (LATCH_MASK[i]) begin : g_flag
      logic vc;
      logic flag_q, flag_d, flag_en;

      if (i < NUM_VEC) begin : g_vc
        assign vc = vclr_i[i];
      end else begin : g_novc
        assign vc = 1'b0;
      end

      always_comb begin
        flag_en = set_i[i] | w1c_i[i] | vc;
        flag_d  = flag_q;
        if (w1c_i[i] | vc) flag_d = 1'b0;
        if (set_i[i])      flag_d = 1'b1;   // event wins over any clear
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (flag_en) flag_q <= flag_d;
      end

      assign stat_o[i] = flag_q;

      p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] && !w1c_i[i] && !vc |=> flag_q);
      p_event_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] && (w1c_i[i] || vc) |=> flag_q);
      p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        w1c_i[i] && !set_i[i] |=> !flag_q);
      p_zero_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !w1c_i[i] && !vc |=> flag_q);
    end else begin : g_zero
      assign stat_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/evt_vec_enc.sv
module evt_vec_enc #(
  parameter int unsigned NUM_VEC = 5,
  parameter int unsigned VEC_W   = $clog2(NUM_VEC + 1)
) (
  input  logic [NUM_VEC-1:0] pend_i,
  output logic [VEC_W-1:0]   code_o,
  output logic [NUM_VEC-1:0] pick_o
);
  always_comb begin
    code_o = '0;
    pick_o = '0;
    for (int k = NUM_VEC - 1; k >= 0; k--) begin
      if (pend_i[k]) begin
        code_o = VEC_W'(k + 1);
        pick_o = '0;
        pick_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import i2c_evt_pkg::*;
#(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned NUM_VEC = 5,
  parameter int unsigned VEC_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [REG_W-1:0]   stat_i,
  input  logic [VEC_W-1:0]   code_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic [REG_W-1:0]   w1c_o,
  output logic               vec_rd_o,
  output logic [NUM_VEC-1:0] en_o
);
  logic [NUM_VEC-1:0] en_q, en_d;
  logic               en_we;

  always_comb begin
    en_we    = wr_i && (addr_i == ADDR_W'(SEL_ENABLE));
    en_d     = wdata_i[NUM_VEC-1:0];
    w1c_o    = (wr_i && (addr_i == ADDR_W'(SEL_STATUS))) ? wdata_i : '0;
    vec_rd_o = rd_i && (addr_i == ADDR_W'(SEL_VECTOR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(SEL_STATUS): rdata_o = stat_i;
      ADDR_W'(SEL_ENABLE): rdata_o = {{(REG_W-NUM_VEC){1'b0}}, en_q};
      ADDR_W'(SEL_VECTOR): rdata_o = {{(REG_W-VEC_W){1'b0}}, code_i};
      default:             rdata_o = '0;
    endcase
  end

  assign en_o = en_q;

  p_enable_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit
  import i2c_evt_pkg::*;
#(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned NUM_VEC = 5,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_arb_lost_i,
  input  logic              ev_nack_i,
  input  logic              ev_acc_rdy_i,
  input  logic              ev_rx_rdy_i,
  input  logic              ev_tx_rdy_i,
  input  logic              ev_rx_ovr_i,
  input  logic              ev_tx_udf_i,
  input  logic              bus_busy_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned VEC_W = $clog2(NUM_VEC + 1);

  logic               rst_s_n;
  logic [REG_W-1:0]   set_v, w1c_v, stat_v;
  logic [NUM_VEC-1:0] en_v, pick_v, vclr_v;
  logic [VEC_W-1:0]   code_v;
  logic               vec_rd;

  evt_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  always_comb begin
    set_v           = '0;
    set_v[BIT_ARB]  = ev_arb_lost_i;
    set_v[BIT_NACK] = ev_nack_i;
    set_v[BIT_ACC]  = ev_acc_rdy_i;
    set_v[BIT_RXR]  = ev_rx_rdy_i;
    set_v[BIT_TXR]  = ev_tx_rdy_i;
    set_v[BIT_UDF]  = ev_tx_udf_i;
    set_v[BIT_OVR]  = ev_rx_ovr_i;
  end

  evt_status_bank #(.REG_W(REG_W), .NUM_VEC(NUM_VEC)) u_bank (
    .clk(clk), .rst_n(rst_s_n), .set_i(set_v), .w1c_i(w1c_v),
    .vclr_i(vclr_v), .busy_i(bus_busy_i), .stat_o(stat_v)
  );

  evt_vec_enc #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_enc (
    .pend_i(stat_v[NUM_VEC-1:0]), .code_o(code_v), .pick_o(pick_v)
  );

  evt_reg_port #(.REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_port (
    .clk(clk), .rst_n(rst_s_n), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .stat_i(stat_v),
    .code_i(code_v), .rdata_o(reg_rdata_o), .w1c_o(w1c_v),
    .vec_rd_o(vec_rd), .en_o(en_v)
  );

  assign vclr_v = vec_rd ? pick_v : '0;
  assign irq_o  = |(stat_v[NUM_VEC-1:0] & en_v);

  p_vec_lowest_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    stat_v[BIT_ARB] |-> code_v == VEC_W'(1));
  p_vec_single_clear_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(vclr_v));
  for (genvar k = 0; k < NUM_VEC; k++) begin : g_vchk
    p_vec_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
      vec_rd && code_v == VEC_W'(k + 1) && !set_v[k] |=> !stat_v[k]);
  end
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    en_v == '0 |-> !irq_o);
endmodule

// File: tb/i2c_evt_irq_unit_tb_top.sv
module i2c_evt_irq_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_al = 0, ev_nk = 0, ev_ar = 0, ev_rr = 0, ev_tr = 0, ev_ov = 0, ev_ud = 0;
  logic busy = 0, wr = 0, rd = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  i2c_evt_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_arb_lost_i(ev_al), .ev_nack_i(ev_nk), .ev_acc_rdy_i(ev_ar),
    .ev_rx_rdy_i(ev_rr), .ev_tx_rdy_i(ev_tr), .ev_rx_ovr_i(ev_ov),
    .ev_tx_udf_i(ev_ud), .bus_busy_i(busy), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // Monitor: pops the expected read value and compares mid-cycle
  always @(negedge clk) begin
    if (rd) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    wr = 0; rd = 0;
    {ev_al, ev_nk, ev_ar, ev_rr, ev_tr, ev_ov, ev_ud} = '0;
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [15:0] d);
    step(); wr = 1; addr = a; wdata = d;
  endtask

  task automatic do_rd(input logic [1:0] a, input logic [15:0] e, input string t);
    step(); rd = 1; addr = a; exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic pulse(input logic [6:0] m);  // {al,nk,ar,rr,tr,ov,ud}
    step(); {ev_al, ev_nk, ev_ar, ev_rr, ev_tr, ev_ov, ev_ud} = m;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1
    chk_irq(0, "R1 irq after reset");
    do_rd(0, 16'h0000, "R1 status");
    do_rd(1, 16'h0000, "R1 enable");
    do_rd(2, 16'h0000, "R1 vector");
    // R2 all events at once
    pulse(7'b1111111);
    do_rd(0, 16'h0C1F, "R2 status bits");
    do_rd(2, 16'h0001, "R9 vector arb");
    do_rd(2, 16'h0002, "R10 next nack");
    do_rd(0, 16'h0C1C, "R10 cleared two");
    step(); chk_irq(0, "R8 no enable");
    // R7
    do_wr(1, 16'hFFFF);
    do_rd(1, 16'h001F, "R7 enable bits");
    chk_irq(1, "R8 enabled");
    // R3
    do_wr(0, 16'h0004);
    do_rd(0, 16'h0C18, "R3 w1c one bit");
    do_wr(0, 16'h0000);
    do_rd(0, 16'h0C18, "R3 zero write");
    do_wr(0, 16'h0C18);
    chk_irq(1, "R8 before clear edge");
    step(); chk_irq(0, "R8 after clear edge");
    // R4 collision
    step(); ev_rr = 1; wr = 1; addr = 0; wdata = 16'h0008;
    do_rd(0, 16'h0008, "R4 event wins");
    chk_irq(1, "R8 rx pending");
    // R5 / R6
    step(); busy = 1; rd = 1; addr = 0; exp_q.push_back(16'h1008); tag_q.push_back("R5 busy live");
    do_wr(0, 16'hFFFF);
    do_rd(0, 16'h1000, "R5 R6 after write all");
    step(); busy = 0; rd = 1; addr = 0; exp_q.push_back(16'h0000); tag_q.push_back("R5 busy follows");
    // R9 ordering
    pulse(7'b0100100);
    step(); chk_irq(1, "R8 two pending");
    do_rd(2, 16'h0002, "R9 nack first");
    do_rd(2, 16'h0005, "R10 tx next");
    do_rd(2, 16'h0000, "R10 drained");
    step(); chk_irq(0, "R8 drained");
    // partial enable
    do_wr(1, 16'h0010);
    pulse(7'b1000000);
    step(); chk_irq(0, "R8 masked");
    do_rd(2, 16'h0001, "R9 ignores enable");
    do_rd(3, 16'h0000, "R11 spare addr");
    do_rd(0, 16'h0000, "R10 vector cleared");
    pulse(7'b0000010);
    do_rd(2, 16'h0000, "R9 overrun not vectored");
    do_rd(0, 16'h0800, "R2 overrun latched");
    do_rd(0, 16'h0800, "R11 status read no side effect");
    step(); chk_irq(0, "R8 overrun no irq");
    step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule